// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block lets software send an arbitrary serial-flash command and collect the reply through a small byte-wide register interface. Software fills up to six outgoing data bytes and writes a total bit count. It then writes a command code that starts the transfer. The opcode always sits in the top data byte. All outgoing and incoming bits pass through one 56-bit window register. The top `N` bits of that window leave on MOSI most significant bit first. Each bit read from MISO enters at the bottom of the window. When the transfer ends, the reply bytes can be read back from the low end of the window.

Two fixed one-byte operations are also provided. The first reads the flash status byte into its own register. The second writes the top data byte to the flash status register. Each uses a built-in opcode and always runs for 16 clocks. No command is accepted until a key value has been written to a guard register. A trigger that arrives while a command is still running is dropped. The serial clock idles low (mode 0). Each SCK phase lasts `HALF_DIV` system clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every readable register returns 0x00, spi_cs_n is high, and spi_sck and spi_mosi are low.
- R2: A command write (address 0x00) starts nothing unless the guard register (address 0x03) holds 0x30. A trigger refused for this reason leaves spi_cs_n high and reads back as 0x00.
- R3: Writing code 0x04 to address 0x00 starts a transfer of N bits, where N is the bit count at address 0x01. spi_cs_n is low for exactly 2*HALF_DIV*N clocks, starting in the cycle after the write. spi_sck gives exactly N rising edges in that time.
- R4: MOSI carries the top N bits of a 56-bit word, most significant bit first. Data byte 5 (address 0x0D) is the top byte of that word and data byte 0 (address 0x08) is below it. The bottom byte of the word is zero, so the opcode goes in data byte 5.
- R5: MISO is sampled on each rising SCK edge and shifted into the bottom of the window. Afterwards the window equals (word << N) with the N received bits ORed into its low N bits. Window byte k (address 0x10+k) holds bits 8k+7..8k, so the last received byte is at k=0 and the first of n received bytes is at k=n-1.
- R6: N=56 is accepted as a full 7-byte transfer. Afterwards the window holds only received bits.
- R7: A 0x04 trigger with N=0 or N>56 is refused: no chip-select activity, and the window is unchanged.
- R8: A trigger written while a command runs is ignored, and so is any code other than 0x02, 0x04 and 0x20. The running transfer keeps its length and data.
- R9: While a command runs, address 0x00 reads back its code. It reads 0x00 from the cycle in which spi_cs_n returns high.
- R10: Code 0x02 sends the built-in status-read opcode, then clocks 8 more bits in, for 16 clocks regardless of N. The byte received last is stored at address 0x02, and only this command changes that register.
- R11: Code 0x20 sends the built-in status-write opcode followed by data byte 5, for 16 clocks regardless of N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the engine with TX_BYTES=6, which fills the data-byte map, and HALF_DIV=3. With these values each SCK phase spans three clocks, so a mid-phase trigger lands while a shift is partly done. Chip-select timing is also checked against a nontrivial divider rather than a one-clock toggle. The default built-in status opcodes (0x05 read, 0x01 write) make the two fixed commands distinguishable on MOSI from a program transfer of the same length.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // register map
  localparam logic [7:0] A_CMD     = 8'h00;
  localparam logic [7:0] A_NBITS   = 8'h01;
  localparam logic [7:0] A_SRDATA  = 8'h02;
  localparam logic [7:0] A_GUARD   = 8'h03;
  localparam logic [7:0] A_TXBASE  = 8'h08;
  localparam logic [7:0] A_WINBASE = 8'h10;

  localparam logic [7:0] KEY_OPEN  = 8'h30;

  typedef enum logic [7:0] {
    OP_IDLE     = 8'h00,
    OP_SR_READ  = 8'h02,
    OP_SHIFT    = 8'h04,
    OP_SR_WRITE = 8'h20
  } cmd_code_e;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int TX_BYTES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               addr,
  input  logic [7:0]               wdata,
  input  logic                     sr_load,
  input  logic [7:0]               sr_value,
  output logic [TX_BYTES-1:0][7:0] tx_bytes,
  output logic [7:0]               nbits,
  output logic [7:0]               guard,
  output logic                     unlocked,
  output logic [7:0]               sr_data
);

  logic [TX_BYTES-1:0][7:0] tx_q, tx_d;
  logic [7:0] nbits_q, nbits_d;
  logic [7:0] guard_q, guard_d;
  logic [7:0] sr_q, sr_d;

  always_comb begin
    tx_d    = tx_q;
    nbits_d = nbits_q;
    guard_d = guard_q;
    sr_d    = sr_q;
    if (wr_en) begin
      if (addr == A_NBITS) nbits_d = wdata;
      if (addr == A_GUARD) guard_d = wdata;
      for (int i = 0; i < TX_BYTES; i++) begin
        if (addr == A_TXBASE + 8'(i)) tx_d[i] = wdata;
      end
    end
    if (sr_load) sr_d = sr_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      nbits_q <= '0;
      guard_q <= '0;
      sr_q    <= '0;
    end else begin
      tx_q    <= tx_d;
      nbits_q <= nbits_d;
      guard_q <= guard_d;
      sr_q    <= sr_d;
    end
  end

  assign tx_bytes = tx_q;
  assign nbits    = nbits_q;
  assign guard    = guard_q;
  assign unlocked = (guard_q == KEY_OPEN);
  assign sr_data  = sr_q;

  // R10
  sr_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sr_q) |-> $past(sr_load));

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int         TX_BYTES = 6,
  parameter int         WIN_BITS = 56,
  parameter int         CNT_W    = 6,
  parameter logic [7:0] SR_RD_OP = 8'h05,
  parameter logic [7:0] SR_WR_OP = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               addr,
  input  logic [7:0]               wdata,
  input  logic                     unlocked,
  input  logic [7:0]               nbits,
  input  logic [TX_BYTES-1:0][7:0] tx_bytes,
  input  logic                     busy,
  input  logic                     done,
  output logic                     start,
  output logic [WIN_BITS-1:0]      load_word,
  output logic [CNT_W-1:0]         load_cnt,
  output logic [7:0]               run_code,
  output logic                     sr_load
);

  logic [WIN_BITS-1:0] prog_word;
  logic                legal;
  logic                cmd_wr;
  logic [7:0]          code_q, code_d;

  // data bytes packed top-down, zero pad byte at the bottom
  for (genvar j = 0; j < TX_BYTES; j++) begin : g_pack
    assign prog_word[WIN_BITS-1-8*j -: 8] = tx_bytes[TX_BYTES-1-j];
  end
  assign prog_word[7:0] = 8'h00;

  assign cmd_wr = wr_en && (addr == A_CMD);

  always_comb begin
    legal     = 1'b0;
    load_word = prog_word;
    load_cnt  = nbits[CNT_W-1:0];
    case (wdata)
      OP_SHIFT: begin
        legal = (nbits != 8'd0) && (nbits <= 8'(WIN_BITS));
      end
      OP_SR_READ: begin
        legal     = 1'b1;
        load_word = {SR_RD_OP, {(WIN_BITS-8){1'b0}}};
        load_cnt  = CNT_W'(16);
      end
      OP_SR_WRITE: begin
        legal     = 1'b1;
        load_word = {SR_WR_OP, tx_bytes[TX_BYTES-1], {(WIN_BITS-16){1'b0}}};
        load_cnt  = CNT_W'(16);
      end
      default: legal = 1'b0;
    endcase
  end

  assign start = cmd_wr && unlocked && !busy && legal;

  always_comb begin
    code_d = code_q;
    if (start)     code_d = wdata;
    else if (done) code_d = OP_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= OP_IDLE;
    else        code_q <= code_d;
  end

  assign run_code = code_q;
  assign sr_load  = done && (code_q == OP_SR_READ);

  // R9
  code_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != OP_IDLE) == busy);

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int WIN_BITS = 56,
  parameter int CNT_W    = 6,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WIN_BITS-1:0] load_word,
  input  logic [CNT_W-1:0]    load_cnt,
  input  logic                miso,
  output logic                active,
  output logic                done,
  output logic                sck,
  output logic                cs_n,
  output logic                mosi,
  output logic [WIN_BITS-1:0] win,
  output logic [7:0]          sr_value
);

  localparam int DIV_W = $clog2(HALF_DIV + 1);

  logic [WIN_BITS-1:0] win_q, win_d;
  logic [CNT_W-1:0]    left_q, left_d;
  logic [DIV_W-1:0]    div_q, div_d;
  logic                sck_q, sck_d;
  logic                act_q, act_d;
  logic                smp_q, smp_d;
  logic                tick;

  assign tick = act_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    win_d  = win_q;
    left_d = left_q;
    div_d  = div_q;
    sck_d  = sck_q;
    act_d  = act_q;
    smp_d  = smp_q;
    if (start) begin
      act_d  = 1'b1;
      win_d  = load_word;
      left_d = load_cnt;
      div_d  = '0;
      sck_d  = 1'b0;
    end else if (act_q) begin
      if (tick) begin
        div_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
          smp_d = miso;
        end else begin
          sck_d  = 1'b0;
          win_d  = {win_q[WIN_BITS-2:0], smp_q};
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) act_d = 1'b0;
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      left_q <= '0;
      div_q  <= '0;
      sck_q  <= 1'b0;
      act_q  <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      win_q  <= win_d;
      left_q <= left_d;
      div_q  <= div_d;
      sck_q  <= sck_d;
      act_q  <= act_d;
      smp_q  <= smp_d;
    end
  end

  assign active   = act_q;
  assign done     = tick && sck_q && (left_q == CNT_W'(1));
  assign sck      = sck_q;
  assign cs_n     = !act_q;
  assign mosi     = act_q && win_q[WIN_BITS-1];
  assign win      = win_q;
  assign sr_value = {win_q[6:0], smp_q};

  // R1
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_q);
  // R3
  cs_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $fell(sck_q));
  // R7
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (load_cnt != '0) && (int'(load_cnt) <= WIN_BITS));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);
  // R4
  win_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !(tick && sck_q)) |=> $stable(win_q));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int         TX_BYTES = 6,
  parameter int         HALF_DIV = 2,
  parameter logic [7:0] SR_RD_OP = 8'h05,
  parameter logic [7:0] SR_WR_OP = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int WIN_BYTES = TX_BYTES + 1;
  localparam int WIN_BITS  = 8 * WIN_BYTES;
  localparam int CNT_W     = $clog2(WIN_BITS + 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [TX_BYTES-1:0][7:0] tx_bytes;
  logic [7:0]          nbits, guard, sr_data, sr_value, run_code;
  logic                unlocked, sr_load, start, busy, done;
  logic [WIN_BITS-1:0] load_word, win;
  logic [CNT_W-1:0]    load_cnt;

  spi_cmd_regs #(.TX_BYTES(TX_BYTES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .sr_load  (sr_load),
    .sr_value (sr_value),
    .tx_bytes (tx_bytes),
    .nbits    (nbits),
    .guard    (guard),
    .unlocked (unlocked),
    .sr_data  (sr_data)
  );

  spi_cmd_ctrl #(
    .TX_BYTES (TX_BYTES),
    .WIN_BITS (WIN_BITS),
    .CNT_W    (CNT_W),
    .SR_RD_OP (SR_RD_OP),
    .SR_WR_OP (SR_WR_OP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .unlocked  (unlocked),
    .nbits     (nbits),
    .tx_bytes  (tx_bytes),
    .busy      (busy),
    .done      (done),
    .start     (start),
    .load_word (load_word),
    .load_cnt  (load_cnt),
    .run_code  (run_code),
    .sr_load   (sr_load)
  );

  spi_cmd_shift #(
    .WIN_BITS (WIN_BITS),
    .CNT_W    (CNT_W),
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .load_word (load_word),
    .load_cnt  (load_cnt),
    .miso      (spi_miso),
    .active    (busy),
    .done      (done),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .win       (win),
    .sr_value  (sr_value)
  );

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_CMD:    reg_rdata = run_code;
      A_NBITS:  reg_rdata = nbits;
      A_SRDATA: reg_rdata = sr_data;
      A_GUARD:  reg_rdata = guard;
      default:  reg_rdata = 8'h00;
    endcase
    for (int i = 0; i < TX_BYTES; i++) begin
      if (reg_addr == A_TXBASE + 8'(i)) reg_rdata = tx_bytes[i];
    end
    for (int k = 0; k < WIN_BYTES; k++) begin
      if (reg_addr == A_WINBASE + 8'(k)) reg_rdata = win[8*k +: 8];
    end
  end

  // R2
  open_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(spi_cs_n) |-> $past(unlocked));

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_cmd_engine #(.TX_BYTES(6), .HALF_DIV(H), .SR_RD_OP(8'h05), .SR_WR_OP(8'h01)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- flash-side model ----------------
  logic [55:0] resp_bits = '0;
  bit          mosi_q[$];
  int          ri = 0;
  int          low_cycles = 0;
  logic        prev_cs = 1'b1, prev_sck = 1'b0;

  always @(negedge clk) begin
    if (spi_cs_n === 1'b0) begin
      low_cycles++;
      if (prev_cs) begin
        spi_miso = resp_bits[55];
        ri = 1;
      end else if (spi_sck && !prev_sck) begin
        mosi_q.push_back(spi_mosi);
        spi_miso = (ri < 56) ? resp_bits[55-ri] : 1'b0;
        ri++;
      end
    end
    prev_cs  = spi_cs_n;
    prev_sck = spi_sck;
  end

  // ---------------- cycle reference model ----------------
  int         m_left = 0;
  logic [7:0] m_guard = 8'h00;
  logic [7:0] m_nbits = 8'h00;
  bit         model_on = 0;

  always @(posedge clk) begin
    if (!model_on) begin
      m_left = 0; m_guard = 0; m_nbits = 0;
    end else begin
      int len;
      len = 0;
      if (reg_wr && reg_addr == 8'h00) begin
        if (reg_wdata == 8'h04 && m_nbits >= 1 && m_nbits <= 56) len = m_nbits;
        if (reg_wdata == 8'h02 || reg_wdata == 8'h20) len = 16;
        if (m_guard != 8'h30) len = 0;
      end
      if (m_left > 0) m_left--;
      else if (len > 0) m_left = 2 * H * len;
      if (reg_wr && reg_addr == 8'h01) m_nbits = reg_wdata;
      if (reg_wr && reg_addr == 8'h03) m_guard = reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R3 cs_n vs model", {63'd0, spi_cs_n}, {63'd0, (m_left == 0)});
      if (spi_cs_n) chk("R1 sck idle", {63'd0, spi_sck}, 64'd0);
    end
  end

  // ---------------- access tasks ----------------
  logic [7:0] tx_m [6];

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_tx(input int i, input logic [7:0] v);
    wr(8'h08 + 8'(i), v);
    tx_m[i] = v;
  endtask

  task automatic rd_win(output logic [55:0] w);
    logic [7:0] b;
    for (int k = 0; k < 7; k++) begin
      rd(8'h10 + 8'(k), b);
      w[8*k +: 8] = b;
    end
  endtask

  function automatic logic [55:0] prog_word();
    return {tx_m[5], tx_m[4], tx_m[3], tx_m[2], tx_m[1], tx_m[0], 8'h00};
  endfunction

  function automatic logic [55:0] mosi_val();
    logic [55:0] v = '0;
    foreach (mosi_q[i]) v = {v[54:0], mosi_q[i]};
    return v;
  endfunction

  // runs one accepted command and checks length, MOSI stream and readback
  task automatic run(input string req, input logic [7:0] code, input int nb,
                     input logic [55:0] resp, input logic [55:0] out_word);
    logic [7:0] b;
    resp_bits = resp;
    mosi_q.delete();
    low_cycles = 0;
    wr(8'h00, code);
    rd(8'h00, b);
    chk({req, " R9 code while busy"}, {56'd0, b}, {56'd0, code});
    while (spi_cs_n === 1'b0) @(negedge clk);
    chk({req, " R3 cs low cycles"}, 64'(low_cycles), 64'(2 * H * nb));
    chk({req, " R3 sck edges"}, 64'(mosi_q.size()), 64'(nb));
    chk({req, " R4 mosi stream"}, {8'd0, mosi_val()}, {8'd0, out_word >> (56 - nb)});
    rd(8'h00, b);
    chk({req, " R9 code cleared"}, {56'd0, b}, 64'd0);
  endtask

  function automatic logic [55:0] exp_win(input logic [55:0] w, input int nb, input logic [55:0] r);
    return (w << nb) | (r >> (56 - nb));
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0]  b;
    logic [55:0] w, w0, word;
    for (int i = 0; i < 6; i++) tx_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // R1 reset state
    rd(8'h00, b); chk("R1 cmd", {56'd0, b}, 64'd0);
    rd(8'h01, b); chk("R1 nbits", {56'd0, b}, 64'd0);
    rd(8'h02, b); chk("R1 status", {56'd0, b}, 64'd0);
    rd(8'h03, b); chk("R1 guard", {56'd0, b}, 64'd0);
    rd(8'h0D, b); chk("R1 tx5", {56'd0, b}, 64'd0);
    rd_win(w);    chk("R1 window", {8'd0, w}, 64'd0);
    chk("R1 pins", {61'd0, spi_cs_n, spi_sck, spi_mosi}, 64'h4);

    // R2 locked: triggers refused
    wr(8'h01, 8'd8);
    set_tx(5, 8'h9F);
    mosi_q.delete();
    wr(8'h00, 8'h04);
    repeat (10) @(negedge clk);
    rd(8'h00, b); chk("R2 locked cmd", {56'd0, b}, 64'd0);
    wr(8'h03, 8'h31);
    wr(8'h00, 8'h02);
    repeat (10) @(negedge clk);
    chk("R2 wrong key no clocks", 64'(mosi_q.size()), 64'd0);
    wr(8'h03, 8'h30);
    rd(8'h03, b); chk("R2 guard readback", {56'd0, b}, 64'h30);

    // R3 R4 R5 identification-style read: opcode + 3 reply bytes
    wr(8'h01, 8'd32);
    word = prog_word();
    run("id", 8'h04, 32, {8'hFF, 8'hEF, 8'h40, 8'h18, 24'h0}, word);
    rd_win(w);
    chk("R5 window", {8'd0, w}, {8'd0, exp_win(word, 32, {8'hFF, 8'hEF, 8'h40, 8'h18, 24'h0})});
    rd(8'h12, b); chk("R5 first reply at k=2", {56'd0, b}, 64'hEF);
    rd(8'h10, b); chk("R5 last reply at k=0", {56'd0, b}, 64'h18);

    // R4 write-type: opcode + five payload bytes
    set_tx(4, 8'h00); set_tx(3, 8'h10); set_tx(2, 8'h00); set_tx(1, 8'hA5); set_tx(0, 8'h3C);
    set_tx(5, 8'h02);
    wr(8'h01, 8'd48);
    run("write", 8'h04, 48, 56'h0, prog_word());

    // R6 full 56-bit window
    set_tx(5, 8'h0B); set_tx(4, 8'h12); set_tx(3, 8'h34); set_tx(2, 8'h56); set_tx(1, 8'h78); set_tx(0, 8'h9A);
    wr(8'h01, 8'd56);
    run("R6 full", 8'h04, 56, 56'hC35A_0F96_E1D2_B4, prog_word());
    rd_win(w);
    chk("R6 window all received", {8'd0, w}, {8'd0, 56'hC35A_0F96_E1D2_B4});

    // R5 non-byte count
    wr(8'h01, 8'd12);
    word = prog_word();
    run("R5 12bit", 8'h04, 12, 56'hABC0_0000_0000_00, word);
    rd_win(w);
    chk("R5 12-bit window", {8'd0, w}, {8'd0, exp_win(word, 12, 56'hABC0_0000_0000_00)});

    // R7 refused counts
    rd_win(w0);
    mosi_q.delete();
    wr(8'h01, 8'd0);  wr(8'h00, 8'h04);
    wr(8'h01, 8'd57); wr(8'h00, 8'h04);
    wr(8'h01, 8'd200); wr(8'h00, 8'h04);
    repeat (8) @(negedge clk);
    chk("R7 no clocks", 64'(mosi_q.size()), 64'd0);
    rd_win(w); chk("R7 window unchanged", {8'd0, w}, {8'd0, w0});

    // R8 unknown code ignored
    wr(8'h00, 8'h07);
    repeat (8) @(negedge clk);
    rd(8'h00, b); chk("R8 unknown code", {56'd0, b}, 64'd0);
    chk("R8 unknown no clocks", 64'(mosi_q.size()), 64'd0);

    // R8 trigger while busy ignored
    set_tx(5, 8'h03); set_tx(4, 8'h01); set_tx(3, 8'h02);
    wr(8'h01, 8'd24);
    word = prog_word();
    resp_bits = 56'h0;
    mosi_q.delete();
    low_cycles = 0;
    wr(8'h00, 8'h04);
    repeat (7) @(negedge clk);
    wr(8'h00, 8'h02);
    rd(8'h00, b); chk("R8 code kept", {56'd0, b}, 64'h04);
    while (spi_cs_n === 1'b0) @(negedge clk);
    chk("R8 length kept", 64'(low_cycles), 64'(2 * H * 24));
    chk("R8 data kept", {8'd0, mosi_val()}, {8'd0, word >> 32});

    // R10 status read, independent of count
    wr(8'h01, 8'd40);
    run("R10 status read", 8'h02, 16, {8'h00, 8'h5A, 40'h0}, {8'h05, 48'h0});
    rd(8'h02, b); chk("R10 status byte", {56'd0, b}, 64'h5A);

    // R11 status write, independent of count
    set_tx(5, 8'h9C);
    run("R11 status write", 8'h20, 16, {8'h00, 8'hFF, 40'h0}, {8'h01, 8'h9C, 40'h0});
    rd(8'h02, b); chk("R10 status unchanged by write", {56'd0, b}, 64'h5A);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule